// File: doc/BRIEF.md
# Serial Trim-Converter Write Master

This block sits on the host side of a three-wire serial link to an octal trim converter. A host hands it one write at a time: a channel address, a value and a frame-format choice, with a valid/ready handshake. The block then runs the whole frame on its own. It lowers the chip select while the serial clock is high and shifts the bits out most significant first. Data changes only while the clock is low. At the end it raises the chip select with the clock still high, which makes the target latch the value into the addressed channel.

Two frame formats are offered. The padded format sends two whole bytes: a first byte whose three low bits hold the address and whose upper bits are zero, then the value byte. The bare format sends only the address bits and then the value bits. The block can also issue an active-low preset pulse of guaranteed minimum width.

A divider parameter sets each serial clock half-period in system cycles. Every other interval (select setup, select hold after the last rising edge, select high time, preset width) is derived from minimum times in picoseconds and the system clock period. Busy and done tell the host when an operation is in flight and when it has ended.

Top module: `tdw_writer`

## Requirements
- R1: After reset, ser_cs_n=1, ser_clk=1, ser_preset_n=1, ser_dat=0, busy=0, done=0, and req_ready=1 while preset_req is low.
- R2: req_ready is high exactly when the block is idle and preset_req is low. A write is accepted on a clock edge where req_valid and req_ready are both high.
- R3: On the edge that accepts a write, ser_cs_n falls while ser_clk stays high. ser_clk stays high for CSS cycles with select low, where CSS = ceil(10 ns / clock period). ser_dat already shows the first frame bit during this time.
- R4: Each frame bit is sent as HALF_DIV cycles of ser_clk low followed by HALF_DIV cycles of ser_clk high. ser_dat changes only in the cycle where ser_clk falls, so it is stable while the clock is high. While idle the clock rests high.
- R5: With req_short=0 the frame is 16 bits, most significant first: five zero bits, the 3 address bits (address MSB first), then the 8 value bits (value MSB first).
- R6: With req_short=1 the frame is 11 bits, most significant first: the 3 address bits, then the 8 value bits.
- R7: After the last bit's high phase, ser_cs_n stays low with ser_clk high for CSH = ceil(15 ns / period) more cycles. It then rises while ser_clk is high.
- R8: After ser_cs_n rises, the block stays busy with select high and clock high for CSW = ceil(10 ns / period) cycles before it returns to idle.
- R9: busy is high from the cycle after acceptance until the block returns to idle. done is a single-cycle pulse in the first idle cycle after every write or preset.
- R10: A preset drives ser_preset_n low for PRE cycles with ser_cs_n and ser_clk held high and ser_dat unchanged. It then returns to idle with a done pulse.
- R11: When preset_req and req_valid are both high in an idle cycle, the preset is taken first. The write is accepted at the first idle edge after the preset, if it is still valid.
- R12: A request presented while busy is not accepted and does not disturb the frame in flight. req_ready stays low until the idle cycle that ends the current operation.
- R13: The preset low time is PRE = ceil(60 ns / period) cycles. Every derived interval is at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a write |
| req_ready | output | 1 | Block can accept a write this cycle |
| req_addr | input | ADDR_W | Target channel address |
| req_data | input | DATA_W | Value for the channel |
| req_short | input | 1 | 1 selects the bare 11-bit frame, 0 the padded two-byte frame |
| preset_req | input | 1 | Request a preset pulse (taken before a write) |
| busy | output | 1 | A frame or preset is in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dat | output | 1 | Serial data, valid around the rising clock |
| ser_cs_n | output | 1 | Active-low chip select |
| ser_preset_n | output | 1 | Active-low preset to the target |

## Verification
The bench builds the block with HALF_DIV=3 and an 8000 ps clock period. This gives select setup, select hold and select high intervals of two cycles and a preset of eight cycles. With a three-cycle half-period, every clock phase lasts several cycles, so a miscount in the phase, setup, hold or gap counters shows up as a shifted edge, and a data change inside a high phase stands apart from the falling edge. Both frame formats are sent with all-zero and all-one values, next to a preset that collides with a write and a second request held through a whole frame.

// File: rtl/tdw_pkg.sv
package tdw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_GAP,
        ST_PRESET
    } tdw_state_e;

    // Whole system cycles covering a minimum time, never below one.
    function automatic int unsigned min_cycles(input int unsigned min_ps,
                                               input int unsigned clk_ps);
        int unsigned c;
        c = (min_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/tdw_frame.sv
module tdw_frame #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int WORD_W = 2 * DATA_W,
    parameter int BL_W   = $clog2(WORD_W + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              short_mode,
    output logic [WORD_W-1:0] word,
    output logic [BL_W-1:0]   nbits
);

    localparam int PAD_W   = DATA_W - ADDR_W;
    localparam int SHORT_N = ADDR_W + DATA_W;

    logic [WORD_W-1:0] padded_word;
    logic [WORD_W-1:0] bare_word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign padded_word = {{PAD_W{1'b0}}, addr, data};
            assign bare_word   = {addr, data, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign padded_word = {addr, data};
            assign bare_word   = {addr, data};
        end
    endgenerate

    always_comb begin
        word  = short_mode ? bare_word : padded_word;
        nbits = short_mode ? BL_W'(SHORT_N) : BL_W'(WORD_W);
    end

endmodule

// File: rtl/tdw_shifter.sv
module tdw_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              msb
);

    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = load_word;
        end else if (shift) begin
            sh_d = {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign msb = sh_q[WORD_W-1];

endmodule

// File: rtl/tdw_timer.sv
module tdw_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/tdw_writer.sv
module tdw_writer #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 2,
    parameter int CLK_PS   = 8000,
    parameter int CSS_PS   = 10000,
    parameter int CSH_PS   = 15000,
    parameter int CSW_PS   = 10000,
    parameter int PRE_PS   = 60000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_short,
    input  logic              preset_req,
    output logic              busy,
    output logic              done,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              ser_cs_n,
    output logic              ser_preset_n
);

    import tdw_pkg::*;

    localparam int WORD_W  = 2 * DATA_W;
    localparam int BL_W    = $clog2(WORD_W + 1);
    localparam int CSS_CYC = int'(min_cycles(CSS_PS, CLK_PS));
    localparam int CSH_CYC = int'(min_cycles(CSH_PS, CLK_PS));
    localparam int CSW_CYC = int'(min_cycles(CSW_PS, CLK_PS));
    localparam int PRE_CYC = int'(min_cycles(PRE_PS, CLK_PS));
    localparam int HALF_C  = (HALF_DIV < 1) ? 1 : HALF_DIV;
    localparam int MAX_A   = (CSS_CYC > CSH_CYC) ? CSS_CYC : CSH_CYC;
    localparam int MAX_B   = (CSW_CYC > PRE_CYC) ? CSW_CYC : PRE_CYC;
    localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_AB > HALF_C) ? MAX_AB : HALF_C;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        tdw_state_e      state;
        logic [BL_W-1:0] bits_left;
        logic            cs_n;
        logic            sclk;
        logic            pre_n;
        logic            done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_zero;
    logic              sh_load;
    logic              sh_shift;
    logic [WORD_W-1:0] frame_word;
    logic [BL_W-1:0]   frame_bits;
    logic              idle;

    tdw_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORD_W (WORD_W),
        .BL_W   (BL_W)
    ) u_frame (
        .addr       (req_addr),
        .data       (req_data),
        .short_mode (req_short),
        .word       (frame_word),
        .nbits      (frame_bits)
    );

    tdw_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (frame_word),
        .shift     (sh_shift),
        .msb       (ser_dat)
    );

    tdw_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    assign idle      = (ctl_q.state == ST_IDLE);
    assign req_ready = idle && !preset_req;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        t_load     = 1'b0;
        t_val      = '0;
        sh_load    = 1'b0;
        sh_shift   = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (preset_req) begin
                    ctl_d.state = ST_PRESET;
                    ctl_d.pre_n = 1'b0;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(PRE_CYC - 1);
                end else if (req_valid) begin
                    ctl_d.state     = ST_SETUP;
                    ctl_d.cs_n      = 1'b0;
                    ctl_d.bits_left = frame_bits - 1'b1;
                    sh_load         = 1'b1;
                    t_load          = 1'b1;
                    t_val           = CNT_W'(CSS_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (t_zero) begin
                    ctl_d.state = ST_LOW;
                    ctl_d.sclk  = 1'b0;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(HALF_C - 1);
                end
            end
            ST_LOW: begin
                if (t_zero) begin
                    ctl_d.state = ST_HIGH;
                    ctl_d.sclk  = 1'b1;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(HALF_C - 1);
                end
            end
            ST_HIGH: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    if (ctl_q.bits_left == '0) begin
                        ctl_d.state = ST_HOLD;
                        t_val       = CNT_W'(CSH_CYC - 1);
                    end else begin
                        ctl_d.state     = ST_LOW;
                        ctl_d.sclk      = 1'b0;
                        ctl_d.bits_left = ctl_q.bits_left - 1'b1;
                        sh_shift        = 1'b1;
                        t_val           = CNT_W'(HALF_C - 1);
                    end
                end
            end
            ST_HOLD: begin
                if (t_zero) begin
                    ctl_d.state = ST_GAP;
                    ctl_d.cs_n  = 1'b1;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(CSW_CYC - 1);
                end
            end
            ST_GAP: begin
                if (t_zero) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            ST_PRESET: begin
                if (t_zero) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.pre_n = 1'b1;
                    ctl_d.done  = 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.cs_n  = 1'b1;
                ctl_d.sclk  = 1'b1;
                ctl_d.pre_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state     <= ST_IDLE;
            ctl_q.bits_left <= '0;
            ctl_q.cs_n      <= 1'b1;
            ctl_q.sclk      <= 1'b1;
            ctl_q.pre_n     <= 1'b1;
            ctl_q.done      <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy         = !idle;
    assign done         = ctl_q.done;
    assign ser_clk      = ctl_q.sclk;
    assign ser_cs_n     = ctl_q.cs_n;
    assign ser_preset_n = ctl_q.pre_n;

endmodule

// File: rtl/tdw_writer_chk.sv
module tdw_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic busy,
    input logic done,
    input logic ser_clk,
    input logic ser_dat,
    input logic ser_cs_n,
    input logic ser_preset_n
);

    p_cs_fall_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_cs_n) |-> (ser_clk && $past(ser_clk)));

    p_dat_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk) && !ser_cs_n && !$past(ser_cs_n)) |-> $stable(ser_dat));

    p_clk_rests_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_clk);

    p_cs_rise_clk_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_cs_n) |-> (ser_clk && $past(ser_clk)));

    p_ready_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_select_implies_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_cs_n |-> busy);

    p_preset_cs_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_preset_n |-> (ser_cs_n && busy));

endmodule

bind tdw_writer tdw_writer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .busy         (busy),
    .done         (done),
    .ser_clk      (ser_clk),
    .ser_dat      (ser_dat),
    .ser_cs_n     (ser_cs_n),
    .ser_preset_n (ser_preset_n)
);

// File: tb/tb_tdw_writer.sv
`timescale 1ns/1ps
module tb_tdw_writer;

    localparam int HALF   = 3;
    localparam int CLKPS  = 8000;
    localparam int CSS    = (10000 + CLKPS - 1) / CLKPS;
    localparam int CSH    = (15000 + CLKPS - 1) / CLKPS;
    localparam int CSW    = (10000 + CLKPS - 1) / CLKPS;
    localparam int PRE    = (60000 + CLKPS - 1) / CLKPS;
    localparam int WD_MAX = 100000;

    typedef struct {
        bit    cs;
        bit    ck;
        bit    dat;
        bit    busy;
        bit    done;
        bit    pre;
        string tag;
        string dtag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       req_short = 1'b0;
    logic       preset_req = 1'b0;
    logic       req_ready, busy, done, ser_clk, ser_dat, ser_cs_n, ser_preset_n;

    int   tests = 0;
    int   fails = 0;
    int   cyc = 0;
    int   pre_run = 0;
    bit   last_dat = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    tdw_writer #(
        .ADDR_W   (3),
        .DATA_W   (8),
        .HALF_DIV (HALF),
        .CLK_PS   (CLKPS)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .req_short    (req_short),
        .preset_req   (preset_req),
        .busy         (busy),
        .done         (done),
        .ser_clk      (ser_clk),
        .ser_dat      (ser_dat),
        .ser_cs_n     (ser_cs_n),
        .ser_preset_n (ser_preset_n)
    );

    function automatic exp_t mk(bit cs, bit ck, bit dat, bit bz, bit dn, bit pr,
                                string tag, string dtag);
        exp_t e;
        e.cs = cs; e.ck = ck; e.dat = dat; e.busy = bz; e.done = dn; e.pre = pr;
        e.tag = tag; e.dtag = dtag;
        return e;
    endfunction

    function automatic int write_len(bit sh);
        int n;
        n = sh ? 11 : 16;
        return CSS + 2 * HALF * n + CSH + CSW + 1;
    endfunction

    // Expected per-cycle outputs for one write, from the requirements.
    task automatic push_write(input logic [2:0] a, input logic [7:0] d, input bit sh);
        bit    bits[$];
        string dt;
        int    n;
        dt = sh ? "R6" : "R5";
        if (!sh) begin
            for (int i = 0; i < 5; i++) bits.push_back(1'b0);
        end
        for (int i = 2; i >= 0; i--) bits.push_back(a[i]);
        for (int i = 7; i >= 0; i--) bits.push_back(d[i]);
        n = bits.size();
        for (int i = 0; i < CSS; i++) q.push_back(mk(0, 1, bits[0], 1, 0, 1, "R3", dt));
        for (int b = 0; b < n; b++) begin
            for (int i = 0; i < HALF; i++) q.push_back(mk(0, 0, bits[b], 1, 0, 1, "R4", dt));
            for (int i = 0; i < HALF; i++) q.push_back(mk(0, 1, bits[b], 1, 0, 1, "R4", dt));
        end
        for (int i = 0; i < CSH; i++) q.push_back(mk(0, 1, bits[n-1], 1, 0, 1, "R7", dt));
        for (int i = 0; i < CSW; i++) q.push_back(mk(1, 1, bits[n-1], 1, 0, 1, "R8", dt));
        q.push_back(mk(1, 1, bits[n-1], 0, 1, 1, "R9", dt));
        last_dat = bits[n-1];
    endtask

    task automatic push_preset(input string tag);
        for (int i = 0; i < PRE; i++) q.push_back(mk(1, 1, last_dat, 1, 0, 0, tag, tag));
        q.push_back(mk(1, 1, last_dat, 0, 1, 1, tag, tag));
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        exp_t  e;
        bit    rdy;
        string t;
        if (rst_n) begin
            if (q.size() > 0) e = q.pop_front();
            else e = mk(1, 1, last_dat, 0, 0, 1, "R12", "R12");
            rdy = !e.busy && !preset_req;
            tests++;
            if (ser_cs_n !== e.cs || ser_clk !== e.ck || ser_dat !== e.dat ||
                busy !== e.busy || done !== e.done || ser_preset_n !== e.pre ||
                req_ready !== rdy) begin
                fails++;
                if (req_ready !== rdy) t = "R2";
                else if (ser_dat !== e.dat) t = e.dtag;
                else t = e.tag;
                $display("FAIL %s cyc=%0d act cs=%b ck=%b dat=%b busy=%b done=%b pre=%b rdy=%b exp cs=%b ck=%b dat=%b busy=%b done=%b pre=%b rdy=%b",
                         t, cyc, ser_cs_n, ser_clk, ser_dat, busy, done, ser_preset_n, req_ready,
                         e.cs, e.ck, e.dat, e.busy, e.done, e.pre, rdy);
            end
        end
    end

    // R13: width of every preset pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_preset_n === 1'b0) pre_run++;
            else if (pre_run != 0) begin
                tests++;
                if (pre_run != PRE) begin
                    fails++;
                    $display("FAIL R13 preset width act=%0d exp=%0d", pre_run, PRE);
                end
                pre_run = 0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_MAX) begin
            fails++;
            $display("FAIL R9 watchdog expired act cycles=%0d exp below %0d", cyc, WD_MAX);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_idle();
        while (q.size() != 0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d, input bit sh);
        wait_idle();
        #2;
        req_valid = 1'b1; req_addr = a; req_data = d; req_short = sh;
        @(posedge clk);
        #1;
        push_write(a, d, sh);
        req_valid = 1'b0;
    endtask

    task automatic do_preset();
        wait_idle();
        #2;
        preset_req = 1'b1;
        @(posedge clk);
        #1;
        push_preset("R10");
        preset_req = 1'b0;
    endtask

    initial begin
        int len;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #2;
        // R1: reset state
        tests++;
        if (ser_cs_n !== 1'b1 || ser_clk !== 1'b1 || ser_preset_n !== 1'b1 ||
            ser_dat !== 1'b0 || busy !== 1'b0 || done !== 1'b0 || req_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 act cs=%b ck=%b pre=%b dat=%b busy=%b done=%b rdy=%b exp 1 1 1 0 0 0 1",
                     ser_cs_n, ser_clk, ser_preset_n, ser_dat, busy, done, req_ready);
        end

        // R5 / R6: both frame formats, mixed and extreme values
        do_write(3'd5, 8'hA5, 1'b0);
        do_write(3'd3, 8'h3C, 1'b1);
        do_write(3'd7, 8'hFF, 1'b0);
        do_write(3'd0, 8'h00, 1'b1);
        do_write(3'd7, 8'hFF, 1'b1);
        do_write(3'd0, 8'h01, 1'b0);

        // R10 / R13: preset alone
        do_preset();

        // R11: preset and write together; preset wins, write follows
        wait_idle();
        #2;
        preset_req = 1'b1;
        req_valid = 1'b1; req_addr = 3'd2; req_data = 8'h81; req_short = 1'b1;
        @(posedge clk);
        #1;
        push_preset("R11");
        preset_req = 1'b0;
        repeat (PRE + 1) @(posedge clk);
        #1;
        push_write(3'd2, 8'h81, 1'b1);
        req_valid = 1'b0;

        // R12: second request held through a whole frame
        wait_idle();
        #2;
        req_valid = 1'b1; req_addr = 3'd1; req_data = 8'h5A; req_short = 1'b0;
        @(posedge clk);
        #1;
        push_write(3'd1, 8'h5A, 1'b0);
        len = write_len(1'b0);
        req_addr = 3'd6; req_data = 8'hC3; req_short = 1'b1;
        for (int k = 1; k < len; k++) begin
            @(posedge clk);
            #3;
            if (k < len - 1) begin
                tests++;
                if (req_ready !== 1'b0) begin
                    fails++;
                    $display("FAIL R12 ready while busy k=%0d act=%b exp=0", k, req_ready);
                end
            end
        end
        @(posedge clk);
        #1;
        push_write(3'd6, 8'hC3, 1'b1);
        req_valid = 1'b0;

        wait_idle();
        repeat (10) @(posedge clk);
        #1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule